// File: doc/BRIEF.md
# Slot-Addressed Voice Record/Playback Controller

This block is the control core of a voice memory whose array is split into sixteen equal slots. A message spans from a chosen start slot through a chosen end slot, both ends included. Three active-low request inputs, already debounced, drive it. A record request starts a recording. An edge-play request toggles playback on each falling edge. A level-play request plays for as long as it is held low. The block drives the row address, the record and play enables, a strobe that writes the end-of-message marker, an active-low LED, and a one-cycle power-down request.

All timing counts sample ticks (`sampleTick`). These timings are the record-length classification, the record and play settle delays, the record-to-play handover gap and the LED pulse. The storage cells are modelled as a row counter plus one end-of-message flag bit per row. A side port lets the flag bits be written and read directly.

Top module: `slot_recplay_ctrl`

## Requirements
- R1: Slot code `k` maps to first row `k*ROWS_PER_SLOT` and last row `k*ROWS_PER_SLOT+ROWS_PER_SLOT-1`. A message covers the first row of the start slot through the last row of the end slot.
- R2: A falling edge on `recReqN` in idle drives `ledN` low at once. After `REC_SETTLE` ticks `recEn` rises, and the row then steps by one on each tick. With `sampleTick` low the row holds.
- R3: If `recReqN` goes high before it has been low for `LEVEL_HOLD` ticks, the recording is in toggle mode, and the next falling edge stops it.
- R4: If `recReqN` stays low for `LEVEL_HOLD` ticks, the recording is in level mode, and releasing the input stops it.
- R5: A recording also stops after the last row of the end slot. Every stop writes flag 1 at the row being recorded, and rows passed earlier in that recording read 0. `ledN` returns high and `pwrDown` pulses once.
- R6: A falling edge on `playEdgeReqN` in idle starts playback. `playEn` rises `PLAY_SETTLE` ticks later. Playback ends after the first flagged row or after the end row, whichever comes first. A second falling edge stops it at once.
- R7: Edge playback that ends on a flagged row drives `ledN` low for exactly `LED_PULSE` ticks before `pwrDown`. Ending at the end row without a flag, or by a second trigger, gives no LED pulse. Every edge playback ends with one `pwrDown` pulse.
- R8: Level playback runs while `playLevelReqN` is low. It wraps from the end row back to the start row with no `pwrDown`. Releasing the input stops it with one `pwrDown`.
- R9: A play request during recording stops the recording in that cycle and writes the marker (`eomWr` high in that cycle). After `HANDOVER+PLAY_SETTLE` ticks the block plays from the start row, with no `pwrDown` in between.
- R10: Slot inputs are latched when an operation starts, and later changes are ignored. `recReqN` has no effect during playback.
- R11: A request whose end slot is below its start slot is rejected. No enable, LED or `pwrDown` activity follows.
- R12: When `memWe` is high, `memDin` is written to flag `memAddr` at the clock edge. `memDout` always shows flag `memAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleTick | input | 1 | Sample-period enable for all timing |
| recReqN | input | 1 | Record request, active low |
| playEdgeReqN | input | 1 | Toggle playback request, active low |
| playLevelReqN | input | 1 | Hold-to-play request, active low |
| startSlot | input | 4 | Start slot code |
| endSlot | input | 4 | End slot code (inclusive) |
| memWe | input | 1 | Flag side-port write enable |
| memAddr | input | ROW_W | Flag side-port row |
| memDin | input | 1 | Flag side-port write data |
| memDout | output | 1 | Flag at `memAddr` |
| rowAddr | output | ROW_W | Current array row |
| recEn | output | 1 | Recording audio into `rowAddr` |
| playEn | output | 1 | Playing audio from `rowAddr` |
| eomWr | output | 1 | End-of-message marker write strobe |
| ledN | output | 1 | LED, active low |
| pwrDown | output | 1 | One-cycle power-down request |

## Verification
The bench measures the exact number of recorded and played rows for the two ways a recording can be classified. A design that counted the hold time off by one, or misread a short press as level mode, would record a different number of rows or never stop. It checks that the flags left behind are exact: a missing clear of an old marker would truncate later playback, and a marker on the wrong row would shift it. It also covers the places where pulses and power-down requests are easy to get wrong. These are the LED pulse on a marker-terminated edge playback versus none on a second trigger or a bare end row, no power-down during level looping or during the record-to-play handover, and an inverted slot range that must do nothing.

// File: rtl/slot_recplay_pkg.sv
package slot_recplay_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RSET,
    ST_RRUN,
    ST_HAND,
    ST_PSET,
    ST_PRUN,
    ST_PWAIT
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;    // capture slots, row <= first row of start slot
    logic rewind;   // row <= first row of latched start slot
    logic advance;  // row <= row + 1
    logic clear;    // flag[row] <= 0
    logic mark;     // flag[row] <= 1
  } dpStrobe_t;

endpackage

// File: rtl/slot_recplay_store.sv
module slot_recplay_store
  import slot_recplay_pkg::*;
#(
  parameter int ROWS_PER_SLOT = 8,
  parameter int SLOT_W        = 4,
  localparam int ROWS         = (1 << SLOT_W) * ROWS_PER_SLOT,
  localparam int ROW_W        = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [SLOT_W-1:0] startIn,
  input  logic [SLOT_W-1:0] endIn,
  input  logic              memWe,
  input  logic [ROW_W-1:0]  memAddr,
  input  logic              memDin,
  output logic              memDout,
  output logic [ROW_W-1:0]  rowAddr,
  output logic              atEnd,
  output logic              eomHere,
  output logic              rangeBad
);

  logic [SLOT_W-1:0] startQ, endQ;
  logic [ROW_W-1:0]  row;
  logic [ROWS-1:0]   eomFlags;

  function automatic logic [ROW_W-1:0] firstRow(input logic [SLOT_W-1:0] s);
    return ROW_W'(s) * ROW_W'(ROWS_PER_SLOT);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ   <= '0;
      endQ     <= '0;
      row      <= '0;
      eomFlags <= '0;
    end else begin
      if (strobe.latch) begin
        startQ <= startIn;
        endQ   <= endIn;
        row    <= firstRow(startIn);
      end else if (strobe.rewind) begin
        row <= firstRow(startQ);
      end else if (strobe.advance) begin
        row <= row + 1'b1;
      end
      if (strobe.clear) eomFlags[row] <= 1'b0;
      if (strobe.mark)  eomFlags[row] <= 1'b1;
      if (memWe)        eomFlags[memAddr] <= memDin;
    end
  end

  assign rowAddr  = row;
  assign atEnd    = (row == firstRow(endQ) + ROW_W'(ROWS_PER_SLOT - 1));
  assign eomHere  = eomFlags[row];
  assign rangeBad = (endIn < startIn);
  assign memDout  = eomFlags[memAddr];

endmodule

// File: rtl/slot_recplay_fsm.sv
module slot_recplay_fsm
  import slot_recplay_pkg::*;
#(
  parameter int LEVEL_HOLD  = 8000,
  parameter int REC_SETTLE  = 32,
  parameter int PLAY_SETTLE = 256,
  parameter int HANDOVER    = 128,
  parameter int LED_PULSE   = 256
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      recN,
  input  logic      playEN,
  input  logic      playLN,
  input  logic      atEnd,
  input  logic      eomHere,
  input  logic      rangeBad,
  output dpStrobe_t strobe,
  output logic      recEn,
  output logic      playEn,
  output logic      eomWr,
  output logic      ledN,
  output logic      pwrDown
);

  localparam int TMR_W   = $clog2(REC_SETTLE + PLAY_SETTLE + HANDOVER + 1);
  localparam int HOLD_W  = $clog2(LEVEL_HOLD + 1);
  localparam int PULSE_W = $clog2(LED_PULSE + 1);

  ctlState_t          state, nxt;
  logic [TMR_W-1:0]   timer, tmrVal;
  logic [HOLD_W-1:0]  pressCnt;
  logic [PULSE_W-1:0] pulseCnt;
  logic levelMode, released, edgePlay, recPrev, playEPrev;
  logic recFall, playFall, playReq, playStop, recStop;
  logic goIdle, pulseGo, loadRec, loadTmr, edgeLoad, edgeNext;

  assign recFall  = recPrev & ~recN;
  assign playFall = playEPrev & ~playEN;
  assign playReq  = playFall | ~playLN;
  assign playStop = edgePlay ? playFall : playLN;
  assign recStop  = levelMode ? recN : (released & recFall);

  always_comb begin
    nxt      = state;
    strobe   = '0;
    goIdle   = 1'b0;
    pulseGo  = 1'b0;
    loadRec  = 1'b0;
    loadTmr  = 1'b0;
    tmrVal   = '0;
    edgeLoad = 1'b0;
    edgeNext = 1'b0;
    case (state)
      ST_IDLE: begin
        if (playReq) begin
          if (!rangeBad) begin
            nxt          = ST_PSET;
            strobe.latch = 1'b1;
            loadTmr      = 1'b1;
            tmrVal       = TMR_W'(PLAY_SETTLE - 1);
            edgeLoad     = 1'b1;
            edgeNext     = playFall;
          end
        end else if (recFall && !rangeBad) begin
          nxt          = ST_RSET;
          strobe.latch = 1'b1;
          loadTmr      = 1'b1;
          tmrVal       = TMR_W'(REC_SETTLE - 1);
          loadRec      = 1'b1;
        end
      end
      ST_RSET, ST_RRUN: begin
        if (playReq) begin
          nxt         = ST_HAND;
          strobe.mark = 1'b1;
          loadTmr     = 1'b1;
          tmrVal      = TMR_W'(HANDOVER - 1);
          edgeLoad    = 1'b1;
          edgeNext    = playFall;
        end else if (recStop) begin
          nxt         = ST_IDLE;
          strobe.mark = 1'b1;
          goIdle      = 1'b1;
        end else if (tick) begin
          if (state == ST_RSET) begin
            if (timer == '0) nxt = ST_RRUN;
          end else if (atEnd) begin
            nxt         = ST_IDLE;
            strobe.mark = 1'b1;
            goIdle      = 1'b1;
          end else begin
            strobe.clear   = 1'b1;
            strobe.advance = 1'b1;
          end
        end
      end
      ST_HAND: begin
        if (playStop) begin
          nxt    = ST_IDLE;
          goIdle = 1'b1;
        end else if (tick && timer == '0) begin
          nxt           = ST_PSET;
          strobe.rewind = 1'b1;
          loadTmr       = 1'b1;
          tmrVal        = TMR_W'(PLAY_SETTLE - 1);
        end
      end
      ST_PSET: begin
        if (playStop) begin
          nxt    = ST_IDLE;
          goIdle = 1'b1;
        end else if (tick && timer == '0) begin
          nxt = ST_PRUN;
        end
      end
      ST_PRUN: begin
        if (playStop) begin
          nxt    = ST_IDLE;
          goIdle = 1'b1;
        end else if (tick) begin
          if (eomHere || atEnd) begin
            pulseGo = eomHere;
            if (!edgePlay) begin
              strobe.rewind = 1'b1;
            end else if (eomHere) begin
              nxt = ST_PWAIT;
            end else begin
              nxt    = ST_IDLE;
              goIdle = 1'b1;
            end
          end else begin
            strobe.advance = 1'b1;
          end
        end
      end
      ST_PWAIT: begin
        if (pulseCnt == '0) begin
          nxt    = ST_IDLE;
          goIdle = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      timer     <= '0;
      pressCnt  <= '0;
      pulseCnt  <= '0;
      levelMode <= 1'b0;
      released  <= 1'b0;
      edgePlay  <= 1'b0;
      recPrev   <= 1'b1;
      playEPrev <= 1'b1;
      pwrDown   <= 1'b0;
    end else begin
      state     <= nxt;
      recPrev   <= recN;
      playEPrev <= playEN;
      pwrDown   <= goIdle;
      if (loadTmr) timer <= tmrVal;
      else if (tick && timer != '0) timer <= timer - 1'b1;
      if (edgeLoad) edgePlay <= edgeNext;
      if (pulseGo) pulseCnt <= PULSE_W'(LED_PULSE);
      else if (tick && pulseCnt != '0) pulseCnt <= pulseCnt - 1'b1;
      if (loadRec) begin
        pressCnt  <= HOLD_W'(1);
        levelMode <= 1'b0;
        released  <= 1'b0;
      end else if ((state == ST_RSET || state == ST_RRUN) && tick && !released && !levelMode) begin
        if (recN) released <= 1'b1;
        else if (pressCnt == HOLD_W'(LEVEL_HOLD - 1)) levelMode <= 1'b1;
        else pressCnt <= pressCnt + 1'b1;
      end
    end
  end

  assign recEn  = (state == ST_RRUN);
  assign playEn = (state == ST_PRUN);
  assign eomWr  = strobe.mark;
  assign ledN   = !(state == ST_RSET || state == ST_RRUN) && (pulseCnt == '0);

endmodule

// File: rtl/slot_recplay_ctrl.sv
module slot_recplay_ctrl
  import slot_recplay_pkg::*;
#(
  parameter int ROWS_PER_SLOT = 8,
  parameter int LEVEL_HOLD    = 8000,
  parameter int REC_SETTLE    = 32,
  parameter int PLAY_SETTLE   = 256,
  parameter int HANDOVER      = 128,
  parameter int LED_PULSE     = 256,
  localparam int SLOT_W       = 4,
  localparam int ROW_W        = $clog2((1 << SLOT_W) * ROWS_PER_SLOT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              recReqN,
  input  logic              playEdgeReqN,
  input  logic              playLevelReqN,
  input  logic [SLOT_W-1:0] startSlot,
  input  logic [SLOT_W-1:0] endSlot,
  input  logic              memWe,
  input  logic [ROW_W-1:0]  memAddr,
  input  logic              memDin,
  output logic              memDout,
  output logic [ROW_W-1:0]  rowAddr,
  output logic              recEn,
  output logic              playEn,
  output logic              eomWr,
  output logic              ledN,
  output logic              pwrDown
);

  dpStrobe_t strobe;
  logic atEnd, eomHere, rangeBad;

  slot_recplay_fsm #(
    .LEVEL_HOLD (LEVEL_HOLD),
    .REC_SETTLE (REC_SETTLE),
    .PLAY_SETTLE(PLAY_SETTLE),
    .HANDOVER   (HANDOVER),
    .LED_PULSE  (LED_PULSE)
  ) fsm_i (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (sampleTick),
    .recN    (recReqN),
    .playEN  (playEdgeReqN),
    .playLN  (playLevelReqN),
    .atEnd   (atEnd),
    .eomHere (eomHere),
    .rangeBad(rangeBad),
    .strobe  (strobe),
    .recEn   (recEn),
    .playEn  (playEn),
    .eomWr   (eomWr),
    .ledN    (ledN),
    .pwrDown (pwrDown)
  );

  slot_recplay_store #(
    .ROWS_PER_SLOT(ROWS_PER_SLOT),
    .SLOT_W       (SLOT_W)
  ) store_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .startIn (startSlot),
    .endIn   (endSlot),
    .memWe   (memWe),
    .memAddr (memAddr),
    .memDin  (memDin),
    .memDout (memDout),
    .rowAddr (rowAddr),
    .atEnd   (atEnd),
    .eomHere (eomHere),
    .rangeBad(rangeBad)
  );

endmodule

// File: rtl/slot_recplay_chk.sv
module slot_recplay_chk #(
  parameter int ROW_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleTick,
  input logic [ROW_W-1:0] rowAddr,
  input logic             recEn,
  input logic             playEn,
  input logic             eomWr,
  input logic             ledN,
  input logic             pwrDown
);

  // R2
  rec_row_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (recEn && $past(recEn) && $past(sampleTick)) |-> rowAddr == $past(rowAddr) + 1'b1);

  // R2
  rec_led_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    recEn |-> !ledN);

  // R5
  rec_stop_marks_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(recEn) |-> $past(eomWr));

  // R6
  rec_play_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(recEn && playEn));

  // R7
  pwr_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrDown |-> (!recEn && !playEn));

  // R8
  play_row_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (playEn && $past(playEn) && $past(sampleTick)) |->
      (rowAddr == $past(rowAddr) + 1'b1 || rowAddr <= $past(rowAddr)));

endmodule

bind slot_recplay_ctrl slot_recplay_chk #(.ROW_W(ROW_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .sampleTick(sampleTick),
  .rowAddr   (rowAddr),
  .recEn     (recEn),
  .playEn    (playEn),
  .eomWr     (eomWr),
  .ledN      (ledN),
  .pwrDown   (pwrDown)
);

// File: tb/slot_recplay_ctrl_tb_top.sv
module slot_recplay_ctrl_tb_top;

  localparam int RPS   = 2;
  localparam int LH    = 20;
  localparam int RS    = 3;
  localparam int PS    = 5;
  localparam int HO    = 4;
  localparam int LP    = 6;
  localparam int ROWS  = 16 * RPS;
  localparam int ROW_W = $clog2(ROWS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleTick = 1'b1;
  logic recReqN = 1'b1, playEdgeReqN = 1'b1, playLevelReqN = 1'b1;
  logic [3:0] startSlot = '0, endSlot = '0;
  logic memWe = 1'b0, memDin = 1'b0;
  logic [ROW_W-1:0] memAddr = '0;
  logic memDout, recEn, playEn, eomWr, ledN, pwrDown;
  logic [ROW_W-1:0] rowAddr;

  always #5 clk = ~clk;

  slot_recplay_ctrl #(
    .ROWS_PER_SLOT(RPS), .LEVEL_HOLD(LH), .REC_SETTLE(RS),
    .PLAY_SETTLE(PS), .HANDOVER(HO), .LED_PULSE(LP)
  ) dut_i (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick),
    .recReqN(recReqN), .playEdgeReqN(playEdgeReqN), .playLevelReqN(playLevelReqN),
    .startSlot(startSlot), .endSlot(endSlot),
    .memWe(memWe), .memAddr(memAddr), .memDin(memDin), .memDout(memDout),
    .rowAddr(rowAddr), .recEn(recEn), .playEn(playEn), .eomWr(eomWr),
    .ledN(ledN), .pwrDown(pwrDown)
  );

  // running totals sampled 3 ns after each falling edge
  int recTot = 0, playTot = 0, pwrTot = 0, ledTot = 0, eomTot = 0, beyondTot = 0, wrapTot = 0;
  int rowLimit = 1000;
  logic [ROW_W-1:0] prevRow = '0;
  logic prevPlay = 1'b0;
  always @(negedge clk) begin
    #3;
    if (rstN) begin
      recTot  += int'(recEn);
      playTot += int'(playEn);
      pwrTot  += int'(pwrDown);
      ledTot  += int'(!ledN);
      eomTot  += int'(eomWr);
      if ((recEn || playEn) && int'(rowAddr) > rowLimit) beyondTot++;
      if (playEn && prevPlay && rowAddr < prevRow) wrapTot++;
    end
    prevRow  = rowAddr;
    prevPlay = playEn;
  end

  int nChk = 0, nFail = 0;
  int bRec, bPlay, bPwr, bLed, bEom, bBeyond, bWrap;

  task automatic checkEq(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic snap();
    bRec = recTot; bPlay = playTot; bPwr = pwrTot; bLed = ledTot;
    bEom = eomTot; bBeyond = beyondTot; bWrap = wrapTot;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeFlag(input int r, input logic v);
    @(negedge clk);
    memAddr = ROW_W'(r); memDin = v; memWe = 1'b1;
    @(negedge clk);
    memWe = 1'b0;
  endtask

  task automatic readFlag(input int r, output int v);
    @(negedge clk);
    memAddr = ROW_W'(r);
    #1 v = int'(memDout);
  endtask

  task automatic clearFlags();
    for (int r = 0; r < ROWS; r++) writeFlag(r, 1'b0);
  endtask

  function automatic int rowsOf(input int s, input int e);
    return (e - s + 1) * RPS;
  endfunction

  function automatic int lastRowOf(input int e);
    return e * RPS + RPS - 1;
  endfunction

  task automatic recToggle(input int s, input int e);
    @(negedge clk);
    startSlot = 4'(s); endSlot = 4'(e); recReqN = 1'b0;
    waitCyc(2);
    recReqN = 1'b1;
    waitCyc(RS + ROWS + 10);
  endtask

  task automatic playEdge(input int s, input int e);
    @(negedge clk);
    startSlot = 4'(s); endSlot = 4'(e); playEdgeReqN = 1'b0;
    waitCyc(2);
    playEdgeReqN = 1'b1;
    waitCyc(PS + ROWS + LP + 10);
  endtask

  initial begin
    int v, n, s, e, rowHeld;
    void'($urandom(32'd4242));
    waitCyc(4);
    #3;
    checkEq("R2 reset ledN", int'(ledN), 1);
    checkEq("R2 reset recEn", int'(recEn), 0);
    checkEq("R6 reset playEn", int'(playEn), 0);
    checkEq("R5 reset pwrDown", int'(pwrDown), 0);
    @(negedge clk);
    rstN = 1'b1;
    waitCyc(2);

    // R12 side port
    writeFlag(9, 1'b1); readFlag(9, v); checkEq("R12 flag write 1", v, 1);
    writeFlag(9, 1'b0); readFlag(9, v); checkEq("R12 flag write 0", v, 0);

    // R1 R3 R5 toggle record to end, slots 1..3 = rows 2..7
    writeFlag(4, 1'b1);
    rowLimit = 7;
    snap();
    recToggle(1, 3);
    checkEq("R1 rows recorded", recTot - bRec, 6);
    checkEq("R2 led low over settle+record", ledTot - bLed, RS + 6);
    checkEq("R5 one pwrDown", pwrTot - bPwr, 1);
    checkEq("R5 one marker strobe", eomTot - bEom, 1);
    checkEq("R1 no row past end slot", beyondTot - bBeyond, 0);
    readFlag(7, v); checkEq("R5 marker at last row", v, 1);
    readFlag(4, v); checkEq("R5 old marker cleared", v, 0);
    rowLimit = 1000;

    // R11 reject inverted range
    snap();
    recToggle(5, 2);
    playEdge(5, 2);
    checkEq("R11 no record", recTot - bRec, 0);
    checkEq("R11 no play", playTot - bPlay, 0);
    checkEq("R11 no led", ledTot - bLed, 0);
    checkEq("R11 no pwrDown", pwrTot - bPwr, 0);

    // R6 R7 edge play ends on marker at row 7
    snap();
    playEdge(1, 3);
    checkEq("R6 rows played to marker", playTot - bPlay, 6);
    checkEq("R7 led pulse length", ledTot - bLed, LP);
    checkEq("R7 pwrDown after play", pwrTot - bPwr, 1);

    // R6 R7 end row without marker
    clearFlags();
    writeFlag(9, 1'b1);
    snap();
    playEdge(3, 3);
    checkEq("R6 rows played to end row", playTot - bPlay, 2);
    checkEq("R7 no pulse at bare end", ledTot - bLed, 0);
    checkEq("R7 pwrDown at bare end", pwrTot - bPwr, 1);

    // R6 marker before end: slots 4..7, marker at row 9
    snap();
    playEdge(4, 7);
    checkEq("R6 marker before end row", playTot - bPlay, 2);
    checkEq("R7 pulse at early marker", ledTot - bLed, LP);
    writeFlag(9, 1'b0);

    // R6 R7 R10 second trigger stops, record ignored during play
    snap();
    @(negedge clk);
    startSlot = 4'd0; endSlot = 4'd15; playEdgeReqN = 1'b0;
    waitCyc(2); playEdgeReqN = 1'b1;
    waitCyc(6); recReqN = 1'b0;
    waitCyc(1); recReqN = 1'b1;
    waitCyc(3); playEdgeReqN = 1'b0;
    waitCyc(2); playEdgeReqN = 1'b1;
    waitCyc(20);
    checkEq("R6 second trigger stop", playTot - bPlay, 7);
    checkEq("R7 no pulse on trigger stop", ledTot - bLed, 0);
    checkEq("R7 pwrDown on trigger stop", pwrTot - bPwr, 1);
    checkEq("R10 record ignored in play", recTot - bRec, 0);

    // R4 level record, held 30 ticks
    snap();
    @(negedge clk);
    startSlot = 4'd0; endSlot = 4'd15; recReqN = 1'b0;
    waitCyc(30); recReqN = 1'b1;
    waitCyc(20);
    checkEq("R4 level rows", recTot - bRec, 30 - RS);
    checkEq("R4 pwrDown", pwrTot - bPwr, 1);
    readFlag(26, v); checkEq("R4 marker at release row", v, 1);
    readFlag(25, v); checkEq("R4 row before cleared", v, 0);

    // R3 toggle stopped by second pulse
    snap();
    @(negedge clk);
    recReqN = 1'b0;
    waitCyc(2); recReqN = 1'b1;
    waitCyc(18); recReqN = 1'b0;
    waitCyc(2); recReqN = 1'b1;
    waitCyc(20);
    checkEq("R3 toggle stop rows", recTot - bRec, 17);
    readFlag(16, v); checkEq("R3 marker at stop row", v, 1);
    checkEq("R3 single pwrDown", pwrTot - bPwr, 1);

    // R10 slot change during record ignored
    rowLimit = 3;
    snap();
    @(negedge clk);
    startSlot = 4'd1; endSlot = 4'd1; recReqN = 1'b0;
    waitCyc(1); startSlot = 4'd0; endSlot = 4'd15;
    waitCyc(1); recReqN = 1'b1;
    waitCyc(RS + ROWS + 5);
    checkEq("R10 latched range rows", recTot - bRec, 2);
    checkEq("R10 no row beyond latched end", beyondTot - bBeyond, 0);
    readFlag(3, v); checkEq("R10 marker at latched end", v, 1);
    rowLimit = 1000;

    // R2 tick gating
    @(negedge clk);
    startSlot = 4'd0; endSlot = 4'd15; recReqN = 1'b0;
    waitCyc(2); recReqN = 1'b1;
    waitCyc(RS + 4);
    #3 rowHeld = int'(rowAddr);
    sampleTick = 1'b0;
    waitCyc(6);
    #3 checkEq("R2 row holds without tick", int'(rowAddr), rowHeld);
    sampleTick = 1'b1;
    waitCyc(ROWS + 10);

    // R9 play pre-empts record
    clearFlags();
    snap();
    @(negedge clk);
    startSlot = 4'd0; endSlot = 4'd15; recReqN = 1'b0;
    waitCyc(2); recReqN = 1'b1;
    n = 0;
    do begin @(negedge clk); #3; n++; end while (!recEn && n < 50);
    waitCyc(5);
    playEdgeReqN = 1'b0;
    #1 checkEq("R9 marker strobe on preempt", int'(eomWr), 1);
    n = 0;
    do begin
      @(negedge clk);
      if (n == 1) playEdgeReqN = 1'b1;
      #3; n++;
    end while (!playEn && n < 100);
    checkEq("R9 handover latency", n, HO + PS + 1);
    checkEq("R9 no pwrDown before play", pwrTot - bPwr, 0);
    waitCyc(ROWS + LP + 10);
    checkEq("R9 rows recorded", recTot - bRec, 6);
    checkEq("R9 just-recorded played", playTot - bPlay, 6);
    checkEq("R9 single pwrDown", pwrTot - bPwr, 1);

    // R8 level loop over slot 2 (rows 4,5)
    clearFlags();
    rowLimit = 5;
    snap();
    @(negedge clk);
    startSlot = 4'd2; endSlot = 4'd2; playLevelReqN = 1'b0;
    waitCyc(40);
    checkEq("R8 no pwrDown while looping", pwrTot - bPwr, 0);
    checkEq("R8 wraps seen", int'((wrapTot - bWrap) >= 2), 1);
    checkEq("R8 rows stay in slot", beyondTot - bBeyond, 0);
    playLevelReqN = 1'b1;
    waitCyc(5);
    #3 checkEq("R8 stop on release", int'(playEn), 0);
    checkEq("R8 pwrDown on release", pwrTot - bPwr, 1);
    rowLimit = 1000;

    // random ranges: record then edge play
    for (int i = 0; i < 6; i++) begin
      s = int'($urandom % 16);
      e = s + int'($urandom % (16 - s));
      snap();
      recToggle(s, e);
      checkEq("R1 random rows recorded", recTot - bRec, rowsOf(s, e));
      readFlag(lastRowOf(e), v);
      checkEq("R5 random marker", v, 1);
      snap();
      playEdge(s, e);
      checkEq("R6 random rows played", playTot - bPlay, rowsOf(s, e));
      checkEq("R7 random pulse", ledTot - bLed, LP);
    end

    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    #2_000_000;
    nChk++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule